// File: doc/BRIEF.md
# Sequencer Status Register with Sticky Flags

This block keeps the 16-bit status word that a host reads back from a program/erase sequencer. It takes single-cycle events from the sequencer and from the host command decoder, and tracks four things: whether an operation is running, a two-step erase suspend, sticky program and erase failure flags, and a low-power (sleep) indication. A protect level is carried straight into the word.

The host reads the word through active-low chip-enable and output-enable strobes. The value is frozen on the clock where both strobes first become active, and it stays put until a new read begins. Two inhibit outputs tell the sequencer that a new program or erase start would be refused, because a failure of that kind has not yet been cleared.

Top module: `seq_status_reg`

## Requirements
- R1: Status bits 1:0 and 15:8 always read as zero. Bit 7 = ready (1 = idle), bit 6 = erase suspended, bit 5 = erase fail, bit 4 = program fail, bit 3 = protect, bit 2 = sleep.
- R2: After reset with protect low and no events, a read returns 16'h0080.
- R3: Bits 5 and 4 are set by a failure event or by an abort. Only a clear-status command clears them, and no sequencer event does.
- R4: While bit 4 (bit 5) is set, a program (erase) start is refused and bit 7 stays 1. The matching inhibit output is high. A start of the other kind is still accepted.
- R5: A suspend request during an erase sets bit 6 while bit 7 stays 0. Bit 7 becomes 1 only on the suspend-reached event.
- R6: Resume clears bit 6 and returns bit 7 to 0 only while suspended. Otherwise it has no effect.
- R7: A sleep request sets bit 2 unless bit 6 is set, in which case it is ignored. Only a read-array command clears bit 2.
- R8: Abort during a running operation ends it (bit 7 = 1, bit 6 = 0), sets bit 2, and sets bit 4 for a program or bit 5 for an erase. Abort with nothing running has no effect.
- R9: status_o captures the live word on the clock where ce_ni and oe_ni are first both low, and holds that value for as long as the read continues.
- R10: Bit 3 reflects protect_i at capture time and is unaffected by clear-status and by sequencer events.
- R11: If a failure event and a clear-status command hit the same flag in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start an operation |
| start_erase_i | input | 1 | Kind of start: 1 = erase, 0 = program |
| done_i | input | 1 | Running operation finished |
| prog_fail_i | input | 1 | Program failure event |
| erase_fail_i | input | 1 | Erase failure event |
| susp_req_i | input | 1 | Erase suspend request |
| susp_done_i | input | 1 | Suspended state reached |
| resume_i | input | 1 | Erase resume command |
| sleep_i | input | 1 | Sleep command |
| abort_i | input | 1 | Abort command |
| rd_array_i | input | 1 | Read-array command |
| clr_stat_i | input | 1 | Clear-status command |
| protect_i | input | 1 | Protect level |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| status_o | output | 16 | Frozen status word |
| prog_inhibit_o | output | 1 | Program starts refused |
| erase_inhibit_o | output | 1 | Erase starts refused |

## Verification
The word is read after program runs and after erase runs, each of which is ended either by completion or by abort. This separates which fail flag an abort sets. A full suspend, reach and resume cycle is compared with resume and sleep requests issued outside a suspend, to show that these take effect only in the right state. Failure and clear arriving together, and a start refused under a pending flag next to a start of the other kind, distinguish the priority rules from the per-kind inhibit. A failure injected while a read is held open shows that the word is frozen.

// File: rtl/seq_stat_pkg.sv
package seq_stat_pkg;
  localparam int STAT_W    = 16;
  localparam int NFAIL     = 2;
  localparam int FAIL_PROG = 0;
  localparam int FAIL_ERAS = 1;
  localparam int B_SLEEP   = 2;
  localparam int B_PROT    = 3;
  localparam int B_PFAIL   = 4;
  localparam int B_EFAIL   = 5;
  localparam int B_SUSP    = 6;
  localparam int B_READY   = 7;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_PROG = 2'd1, OP_ERAS = 2'd2} op_e;
endpackage

// File: rtl/seq_stat_sticky.sv
module seq_stat_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/seq_stat_core.sv
module seq_stat_core
  import seq_stat_pkg::*;
#(
  parameter int NF = NFAIL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          start_erase_i,
  input  logic          done_i,
  input  logic          susp_req_i,
  input  logic          susp_done_i,
  input  logic          resume_i,
  input  logic          sleep_i,
  input  logic          abort_i,
  input  logic          rd_array_i,
  input  logic [NF-1:0] fail_q_i,
  output logic [NF-1:0] abort_fail_o,
  output logic          ready_o,
  output logic          susp_o,
  output logic          sleep_o
);
  op_e  kind_q;
  logic abort_ok, start_ok, req_inh;

  assign req_inh  = start_erase_i ? fail_q_i[FAIL_ERAS] : fail_q_i[FAIL_PROG];
  assign abort_ok = abort_i && (kind_q != OP_NONE);
  assign start_ok = start_i && ready_o && !susp_o && (kind_q == OP_NONE) && !req_inh;

  always_comb begin
    abort_fail_o = '0;
    abort_fail_o[FAIL_PROG] = abort_ok && (kind_q == OP_PROG);
    abort_fail_o[FAIL_ERAS] = abort_ok && (kind_q == OP_ERAS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= OP_NONE;
      ready_o <= 1'b1;
      susp_o  <= 1'b0;
    end else if (abort_ok) begin
      kind_q  <= OP_NONE;
      ready_o <= 1'b1;
      susp_o  <= 1'b0;
    end else if (start_ok) begin
      kind_q  <= start_erase_i ? OP_ERAS : OP_PROG;
      ready_o <= 1'b0;
    end else if (done_i && kind_q != OP_NONE && !susp_o) begin
      kind_q  <= OP_NONE;
      ready_o <= 1'b1;
    end else if (susp_req_i && kind_q == OP_ERAS && !susp_o) begin
      susp_o  <= 1'b1;
    end else if (susp_done_i && susp_o && !ready_o) begin
      ready_o <= 1'b1;
    end else if (resume_i && susp_o) begin
      susp_o  <= 1'b0;
      ready_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sleep_o <= 1'b0;
    else if (abort_ok)            sleep_o <= 1'b1;
    else if (sleep_i && !susp_o)  sleep_o <= 1'b1;
    else if (rd_array_i)          sleep_o <= 1'b0;
  end
endmodule

// File: rtl/seq_stat_capture.sv
module seq_stat_capture #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         oe_ni,
  input  logic [W-1:0] live_i,
  output logic         rd_start_o,
  output logic [W-1:0] word_o
);
  logic rd_act, rd_act_q;
  assign rd_act     = !ce_ni && !oe_ni;
  assign rd_start_o = rd_act && !rd_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q <= 1'b0;
      word_o   <= RST_VAL;
    end else begin
      rd_act_q <= rd_act;
      if (rd_start_o) word_o <= live_i;
    end
  end
endmodule

// File: rtl/seq_status_reg.sv
module seq_status_reg
  import seq_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_erase_i,
  input  logic              done_i,
  input  logic              prog_fail_i,
  input  logic              erase_fail_i,
  input  logic              susp_req_i,
  input  logic              susp_done_i,
  input  logic              resume_i,
  input  logic              sleep_i,
  input  logic              abort_i,
  input  logic              rd_array_i,
  input  logic              clr_stat_i,
  input  logic              protect_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  output logic [STAT_W-1:0] status_o,
  output logic              prog_inhibit_o,
  output logic              erase_inhibit_o
);
  localparam logic [STAT_W-1:0] RST_WORD = STAT_W'(1) << B_READY;

  logic [NFAIL-1:0]  ev_fail, abort_fail, fail_q;
  logic              ready_w, susp_w, sleep_w, rd_start_w;
  logic [STAT_W-1:0] live_w;

  always_comb begin
    ev_fail = '0;
    ev_fail[FAIL_PROG] = prog_fail_i;
    ev_fail[FAIL_ERAS] = erase_fail_i;
  end

  seq_stat_core #(.NF(NFAIL)) u_core (
    .clk_i, .rst_ni, .start_i, .start_erase_i, .done_i, .susp_req_i,
    .susp_done_i, .resume_i, .sleep_i, .abort_i, .rd_array_i,
    .fail_q_i(fail_q), .abort_fail_o(abort_fail),
    .ready_o(ready_w), .susp_o(susp_w), .sleep_o(sleep_w)
  );

  for (genvar g = 0; g < NFAIL; g++) begin : g_fail
    seq_stat_sticky u_flag (
      .clk_i, .rst_ni,
      .set_i(ev_fail[g] | abort_fail[g]),
      .clr_i(clr_stat_i),
      .q_o(fail_q[g])
    );
  end

  always_comb begin
    live_w          = '0;
    live_w[B_READY] = ready_w;
    live_w[B_SUSP]  = susp_w;
    live_w[B_EFAIL] = fail_q[FAIL_ERAS];
    live_w[B_PFAIL] = fail_q[FAIL_PROG];
    live_w[B_PROT]  = protect_i;
    live_w[B_SLEEP] = sleep_w;
  end

  seq_stat_capture #(.W(STAT_W), .RST_VAL(RST_WORD)) u_cap (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .live_i(live_w),
    .rd_start_o(rd_start_w), .word_o(status_o)
  );

  assign prog_inhibit_o  = fail_q[FAIL_PROG];
  assign erase_inhibit_o = fail_q[FAIL_ERAS];
endmodule

// File: rtl/seq_status_reg_chk.sv
module seq_status_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        start_erase_i,
  input logic        sleep_i,
  input logic        abort_i,
  input logic        resume_i,
  input logic        clr_stat_i,
  input logic        prog_fail_i,
  input logic        protect_i,
  input logic        ce_ni,
  input logic        oe_ni,
  input logic        rd_start_w,
  input logic [15:0] live_w,
  input logic [15:0] status_o,
  input logic        prog_inhibit_o
);
  a_r1_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15:8] == 8'h00 && status_o[1:0] == 2'b00);

  a_r3_pfail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_w[4] && !clr_stat_i |=> live_w[4]);

  a_r4_prog_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_inhibit_o && start_i && !start_erase_i && live_w[7] && !resume_i |=> live_w[7]);

  a_r5_susp_two_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(live_w[6]) |-> !live_w[7]);

  a_r7_sleep_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i && live_w[6] && !live_w[2] && !abort_i |=> !live_w[2]);

  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |=> $stable(status_o));

  a_r10_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_w |=> status_o[3] == $past(protect_i));

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_fail_i && clr_stat_i |=> live_w[4]);
endmodule

bind seq_status_reg seq_status_reg_chk i_chk (
  .clk_i, .rst_ni, .start_i, .start_erase_i, .sleep_i, .abort_i, .resume_i,
  .clr_stat_i, .prog_fail_i, .protect_i, .ce_ni, .oe_ni,
  .rd_start_w, .live_w, .status_o, .prog_inhibit_o
);

// File: tb/test_seq_status_reg.sv
module test_seq_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, start_erase, done, pfail, efail, sreq, sdone, resume, sleep, abort_c, rdarr, clr, prot;
  logic ce_n, oe_n;
  logic [15:0] status;
  logic p_inh, e_inh;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  seq_status_reg i_seq_status_reg (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_erase_i(start_erase),
    .done_i(done), .prog_fail_i(pfail), .erase_fail_i(efail), .susp_req_i(sreq),
    .susp_done_i(sdone), .resume_i(resume), .sleep_i(sleep), .abort_i(abort_c),
    .rd_array_i(rdarr), .clr_stat_i(clr), .protect_i(prot), .ce_ni(ce_n),
    .oe_ni(oe_n), .status_o(status), .prog_inhibit_o(p_inh), .erase_inhibit_o(e_inh)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    {start, start_erase, done, pfail, efail, sreq, sdone, resume, sleep, abort_c, rdarr, clr} = '0;
  endtask

  // one-cycle event, driven between edges
  task automatic pulse(input int which, input logic kind = 1'b0);
    @(negedge clk);
    case (which)
      0: begin start = 1'b1; start_erase = kind; end
      1: done = 1'b1;
      2: pfail = 1'b1;
      3: efail = 1'b1;
      4: sreq = 1'b1;
      5: sdone = 1'b1;
      6: resume = 1'b1;
      7: sleep = 1'b1;
      8: abort_c = 1'b1;
      9: rdarr = 1'b1;
      10: clr = 1'b1;
      11: begin pfail = 1'b1; clr = 1'b1; end
      default: ;
    endcase
    @(negedge clk);
    idle_all();
  endtask

  task automatic rd(input string req, input logic [15:0] exp);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk(req, status, exp);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset();
    rd("R2", 16'h0080);
    prot = 1'b1;
    rd("R10", 16'h0088);
    prot = 1'b0;
    rd("R1", 16'h0080);
  endtask

  task automatic t_basic();
    pulse(0, 1'b0); rd("R1 busy", 16'h0000);
    pulse(1);       rd("R1 done", 16'h0080);
  endtask

  task automatic t_sticky();
    pulse(2); rd("R3", 16'h0090);
    chk("R4 inhibit", {15'd0, p_inh}, 16'd1);
    pulse(0, 1'b0); rd("R4 refused", 16'h0090);
    pulse(0, 1'b1); rd("R4 other kind", 16'h0010);
    pulse(1);       rd("R3 kept after done", 16'h0090);
    prot = 1'b1; pulse(10); prot = 1'b0;
    rd("R3 clear", 16'h0080);
    chk("R4 inhibit off", {15'd0, p_inh}, 16'd0);
    pulse(11); rd("R11", 16'h0090);
    pulse(10); rd("R11 clear", 16'h0080);
  endtask

  task automatic t_suspend();
    pulse(0, 1'b1); rd("R5 busy", 16'h0000);
    pulse(4);       rd("R5 step1", 16'h0040);
    pulse(5);       rd("R5 step2", 16'h00C0);
    pulse(7);       rd("R7 ignored", 16'h00C0);
    pulse(6);       rd("R6 resume", 16'h0000);
    pulse(6);       rd("R6 no effect busy", 16'h0000);
    pulse(1);       rd("R6 done", 16'h0080);
    pulse(6);       rd("R6 no effect idle", 16'h0080);
  endtask

  task automatic t_abort();
    pulse(0, 1'b0); pulse(8); rd("R8 prog", 16'h0094);
    pulse(9);  rd("R7 wake", 16'h0090);
    pulse(10); rd("R8 clr", 16'h0080);
    pulse(0, 1'b1); pulse(8); rd("R8 erase", 16'h00A4);
    pulse(9); pulse(10);
    chk("R4 erase inhibit off", {15'd0, e_inh}, 16'd0);
    pulse(8); rd("R8 idle no effect", 16'h0080);
  endtask

  task automatic t_sleep();
    pulse(7); rd("R7 sleep", 16'h0084);
    pulse(10); rd("R7 clr keeps", 16'h0084);
    pulse(9); rd("R7 wake", 16'h0080);
  endtask

  task automatic t_frozen();
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk("R9 first", status, 16'h0080);
    pfail = 1'b1;
    @(negedge clk);
    pfail = 1'b0;
    @(negedge clk);
    chk("R9 held", status, 16'h0080);
    ce_n = 1'b1; oe_n = 1'b1;
    rd("R9 new read", 16'h0090);
    pulse(10);
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_all();
    prot = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_sticky();
    t_suspend();
    t_abort();
    t_sleep();
    t_frozen();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule